// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block guards a system against stalled software. A prescaler divides the slow clock down to a watchdog tick, 256 Hz at the default ratio of 128. On every tick a 12-bit down-counter steps toward zero. When the counter runs out while the watchdog is armed, the block raises a reset request pulse of fixed length. It then reloads and keeps counting. Software avoids the reset by sending a restart command that carries the correct 8-bit key before the counter runs out.

The block leaves reset already armed, with the longest timeout of 4096 ticks (16 s at 256 Hz). Software gets exactly one write to the mode port per reset. That write sets the reload value and chooses between armed and disarmed. Every later mode write is dropped until the next reset. A disarmed watchdog freezes its counter and never requests a reset. The reset input is active low and asynchronous. Its release is expected to be synchronous to the slow clock.

Top module: `wdog_once`

## Requirements
- R1: After reset, rst_req is low and the watchdog is armed with reload value 4095. Without any restart, rst_req first goes high after exactly 4096*DIV rising edges of clk_slow, counted from the first edge after reset release.
- R2: The counter moves only on a tick. Ticks come once every DIV slow-clock cycles, on edges DIV, 2*DIV, and so on after reset release. A tick that finds the counter at zero is an expiry, so a reload value T gives T+1 ticks to expiry.
- R3: A restart (kick high) whose kick_key equals 8'hA5 reloads the counter with the current reload value. A restart with any other key has no effect.
- R4: The first mode write after reset is accepted. The reload value becomes mode_timeout, the watchdog is armed when mode_disable is 0 and disarmed when it is 1, and the counter is loaded with mode_timeout on the same edge.
- R5: Every mode write after the first is ignored until the next reset. The expiry timing stays that of the first write.
- R6: Once disarmed by the accepted write, the counter holds and rst_req stays low until reset.
- R7: An expiry drives rst_req high for exactly PULSE_LEN clk_slow cycles, starting on the edge of the expiring tick. On that same edge the counter reloads, and counting continues.
- R8: A valid restart in the same cycle as an expiring tick wins. The counter reloads and no reset request is raised.
- R9: A reset re-opens the single mode write and restores the power-on mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock (32.768 kHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| mode_wr | input | 1 | Mode write strobe, one cycle per write |
| mode_timeout | input | 12 | Reload value carried by a mode write |
| mode_disable | input | 1 | 1 disarms the watchdog in a mode write |
| kick | input | 1 | Restart command strobe |
| kick_key | input | 8 | Key qualifying the restart, must be 8'hA5 |
| rst_req | output | 1 | Reset request pulse, PULSE_LEN cycles long |

## Verification
The collision that matters is a restart arriving on the same edge as the tick that would expire the counter. A second collision is a mode write landing on an expiring tick. The restart case is forced directly: the reload value is set to zero, so every tick expires, and the restart is held high across many ticks. No request may appear in that time, and a request must appear on the first tick after the restart stops. The write case, together with restarts on random edges, random keys and repeated writes, is judged each cycle against a bench model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int CNT_W = 12;
  parameter int KEY_W = 8;
  typedef logic [CNT_W-1:0] wdt_cnt_t;
  localparam wdt_cnt_t CNT_MAX = '1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    if (div_q == LAST) div_d = '0;
    else               div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = (div_q == LAST);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  wdt_cnt_t wr_timeout,
  input  logic     wr_disable,
  output logic     accept,
  output logic     enabled,
  output logic     next_enabled,
  output wdt_cnt_t reload_val
);
  logic     locked_q, en_q;
  wdt_cnt_t load_q;

  assign accept       = wr && !locked_q;
  assign reload_val   = accept ? wr_timeout : load_q;
  assign next_enabled = accept ? !wr_disable : en_q;
  assign enabled      = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      en_q     <= 1'b1;
      load_q   <= CNT_MAX;
    end else if (accept) begin
      locked_q <= 1'b1;
      en_q     <= !wr_disable;
      load_q   <= wr_timeout;
    end
  end

  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> ($stable(load_q) && $stable(en_q))); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     enabled,
  input  logic     accept,
  input  logic     kick_ok,
  input  wdt_cnt_t reload_val,
  output logic     rst_req
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PL = PW'(PULSE_LEN);

  wdt_cnt_t      cnt_q, cnt_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          expire;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (accept || (enabled && kick_ok)) begin
      cnt_d = reload_val;
    end else if (enabled && tick) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = reload_val;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (expire)          pc_d = PL;
    else if (pc_q != '0) pc_d = pc_q - 1'b1;
    else                 pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MAX;
      pc_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
    end
  end

  assign rst_req = (pc_q != '0);

  AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_ok && enabled && !rst_req) |=> !rst_req); // R8
  AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(tick)); // R2
endmodule

// File: rtl/wdog_once.sv
module wdog_once
  import wdt_pkg::*;
#(
  parameter int              DIV       = 128,
  parameter int              PULSE_LEN = 4,
  parameter logic [KEY_W-1:0] KICK_KEY = 8'hA5
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [CNT_W-1:0] mode_timeout,
  input  logic             mode_disable,
  input  logic             kick,
  input  logic [KEY_W-1:0] kick_key,
  output logic             rst_req
);
  logic     tick, accept, enabled, next_en, kick_ok;
  wdt_cnt_t reload_val;

  assign kick_ok = kick && (kick_key == KICK_KEY);

  wdt_prescaler #(.DIV(DIV)) i_presc (
    .clk(clk_slow), .rst_n(rst_n), .tick(tick)
  );

  wdt_mode_reg i_mode (
    .clk(clk_slow), .rst_n(rst_n), .wr(mode_wr), .wr_timeout(mode_timeout),
    .wr_disable(mode_disable), .accept(accept), .enabled(enabled),
    .next_enabled(next_en), .reload_val(reload_val)
  );

  wdt_counter #(.PULSE_LEN(PULSE_LEN)) i_cnt (
    .clk(clk_slow), .rst_n(rst_n), .tick(tick), .enabled(enabled),
    .accept(accept), .kick_ok(kick_ok), .reload_val(reload_val),
    .rst_req(rst_req)
  );

  AST_DISARMED_QUIET: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!enabled && !next_en && !rst_req) |=> !rst_req); // R6
endmodule

// File: tb/test_wdog_once.sv
module test_wdog_once;
  localparam int DIV_T = 4;
  localparam int PL_T  = 3;
  localparam logic [7:0] KEY = 8'hA5;

  logic clk_slow = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [11:0] mode_timeout = '0;
  logic mode_disable = 1'b0;
  logic kick = 1'b0;
  logic [7:0] kick_key = '0;
  logic rst_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  wdog_once #(.DIV(DIV_T), .PULSE_LEN(PL_T), .KICK_KEY(KEY)) i_wdog_once (
    .clk_slow(clk_slow), .rst_n(rst_n), .mode_wr(mode_wr),
    .mode_timeout(mode_timeout), .mode_disable(mode_disable),
    .kick(kick), .kick_key(kick_key), .rst_req(rst_req)
  );

  always #5 clk_slow = ~clk_slow;

  // reference model written from the requirements
  int m_div, m_cnt, m_load, m_pc;
  bit m_en, m_lock;

  always @(posedge clk_slow) begin
    cycles++;
    if (!rst_n) begin
      m_div = 0; m_cnt = 4095; m_load = 4095; m_en = 1; m_lock = 0; m_pc = 0;
    end else begin
      bit tk, exp_now, kok;
      tk = (m_div == DIV_T - 1);
      kok = kick && (kick_key == KEY);
      exp_now = 0;
      if (mode_wr && !m_lock) begin
        m_lock = 1; m_en = !mode_disable; m_load = mode_timeout; m_cnt = mode_timeout;
      end else if (m_en && kok) begin
        m_cnt = m_load;
      end else if (m_en && tk) begin
        if (m_cnt == 0) begin exp_now = 1; m_cnt = m_load; end
        else m_cnt = m_cnt - 1;
      end
      if (exp_now) m_pc = PL_T;
      else if (m_pc != 0) m_pc = m_pc - 1;
      m_div = tk ? 0 : m_div + 1;
    end
  end

  always @(negedge clk_slow) begin
    if (rst_n) begin
      checks++;
      if (rst_req !== (m_pc != 0)) begin
        errors++;
        $display("FAIL model R3 R4 R7: rst_req=%0b expected %0b at cycle %0d",
                 rst_req, (m_pc != 0), cycles);
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_slow);
    rst_n = 1'b0; mode_wr = 0; kick = 0;
    repeat (2) @(negedge clk_slow);
    rst_n = 1'b1;
  endtask

  // counts posedges until rst_req seen high at a negedge
  task automatic wait_rise(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk_slow); n++;
      @(negedge clk_slow);
      mode_wr = 1'b0;
      if (rst_req) break;
    end
  endtask

  task automatic pulse_len(output int w);
    w = 1;
    forever begin
      @(negedge clk_slow);
      if (!rst_req) break;
      w++;
    end
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog: bench hung, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, w, quiet;
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk_slow);
    check("R1 reset low", rst_req, 0);

    // R1/R2: default timeout
    do_reset();
    wait_rise(5000 * DIV_T, n);
    check("R1 default expiry edge", n, 4096 * DIV_T);
    pulse_len(w);
    check("R7 pulse width", w, PL_T);
    wait_rise(5000 * DIV_T, n);
    check("R7 reload period", n + w, 4096 * DIV_T);

    // R4 first write, R5 later write ignored
    do_reset();
    mode_wr = 1; mode_timeout = 12'd9; mode_disable = 0;
    wait_rise(1000, n);
    check("R4 programmed expiry", n, 10 * DIV_T);
    @(negedge clk_slow);
    mode_wr = 1; mode_timeout = 12'd2; mode_disable = 1;
    @(negedge clk_slow); mode_wr = 0;
    wait_rise(1000, n);
    check("R5 write ignored period", n + 2, 10 * DIV_T);

    // R3 bad key ignored, good key restarts
    do_reset();
    mode_wr = 1; mode_timeout = 12'd3; mode_disable = 0;
    @(negedge clk_slow); mode_wr = 0;
    kick = 1; kick_key = 8'h5A;
    wait_rise(1000, n);
    check("R3 bad key no effect", n + 1, 4 * DIV_T);
    kick = 0;
    do_reset();
    mode_wr = 1; mode_timeout = 12'd3; mode_disable = 0;
    @(negedge clk_slow); mode_wr = 0;
    quiet = 0;
    for (int i = 0; i < 40 * DIV_T; i++) begin
      kick = ((i % (2 * DIV_T)) == 0); kick_key = KEY;
      @(negedge clk_slow);
      if (rst_req) quiet++;
    end
    kick = 0;
    check("R3 good key prevents reset", quiet, 0);

    // R8 restart on every expiring tick
    do_reset();
    mode_wr = 1; mode_timeout = 12'd0; mode_disable = 0;
    @(negedge clk_slow); mode_wr = 0;
    kick = 1; kick_key = KEY;
    quiet = 0;
    for (int i = 0; i < 20 * DIV_T; i++) begin
      @(negedge clk_slow);
      if (rst_req) quiet++;
    end
    check("R8 kick beats expiry", quiet, 0);
    kick = 0;
    wait_rise(100, n);
    check("R8 expiry once kicks stop", (n <= DIV_T) ? 1 : 0, 1);

    // R6 disarmed
    do_reset();
    mode_wr = 1; mode_timeout = 12'd0; mode_disable = 1;
    @(negedge clk_slow); mode_wr = 0;
    quiet = 0;
    for (int i = 0; i < 4200 * DIV_T; i++) begin
      if (i == 100) begin mode_wr = 1; mode_disable = 0; end
      if (i == 101) mode_wr = 0;
      @(negedge clk_slow);
      if (rst_req) quiet++;
    end
    check("R6 disarmed never requests", quiet, 0);

    // R9 reset re-opens the write
    do_reset();
    mode_wr = 1; mode_timeout = 12'd5; mode_disable = 0;
    wait_rise(1000, n);
    check("R9 write accepted after reset", n, 6 * DIV_T);

    // random phase against the model (R3 R4 R5 R7 R8)
    for (int i = 0; i < 30000; i++) begin
      if (i % 6000 == 0) do_reset();
      @(negedge clk_slow);
      kick = ($urandom % 6) == 0;
      kick_key = (($urandom % 2) == 0) ? KEY : 8'($urandom);
      mode_wr = ($urandom % 300) == 0;
      mode_timeout = 12'($urandom % 12);
      mode_disable = ($urandom % 5) == 0;
    end
    @(negedge clk_slow);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule